// File: doc/BRIEF.md
# Delay Tap Calibration Search Engine

This block centres a read-strobe delay setting by searching for the edges of the window of tap values at which a memory pattern test passes. Starting from a tap value that software or reset logic supplies, it steps the tap upward one setting at a time until a test fails or the tap reaches a fixed ceiling. It then goes back to the starting value and steps downward until a test fails or the tap reaches zero. Both taps always carry the setting under test while a test is running.

The pattern test itself is carried out by an external memory tester. The engine asks for one test with a request pulse, and the tester answers with a done pulse and a pass/fail flag. A setting counts as good only after two passing tests in a row. The engine also contains a pure combinational pattern source: the tester gives a word address and gets back the word that it should write and later compare. When the search ends, lane 0 receives the rounded-down midpoint of the passing window, lane 1 receives the midpoint plus one, and `done` rises.

Top module: `tapcal_top`

## Requirements
- R1: `patWord` for word address `patAddr` is built as follows: the group index g is `patAddr[9:2]`, k is `patAddr[1:0]`, bits 31:16 are all ones when bit 2k+1 of g is set, and bits 15:0 are all ones when bit 2k of g is set. All other bits are zero.
- R2: A `start` pulse while idle loads `startTap` into `tap0` and `tap1` at the next clock edge and clears `done`.
- R3: Each test request is a one-cycle `chkReq` pulse. While it is high, `tap0` and `tap1` are equal. The engine then waits for a `chkDone` pulse, however many cycles that takes.
- R4: A setting passes only after two consecutive passing tests. The first failing test ends the evaluation of that setting, so a passing setting uses exactly two requests and a failing one uses exactly one.
- R5: Going upward, a passing setting below 32 is followed by the setting plus one. A passing setting of 32 or above records the upper edge as that setting. A failing setting records the upper edge as the setting minus one. Either of these edge cases makes the search restart downward from the starting tap.
- R6: Going downward, a failing setting records the lower edge as the setting plus one and ends the search. A passing setting of zero records the lower edge as zero and ends the search. Any other passing setting is followed by the setting minus one.
- R7: At the end, `tap0` = floor((upper + lower) / 2), computed without overflow for edges up to 63, and `tap1` = `tap0` + 1 modulo 64. `done` then rises and holds, and both taps hold their values while idle.
- R8: `start` is ignored while a search is running.
- R9: After reset, `tap0` and `tap1` are 0, and `done` and `chkReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| startTap | input | 6 | Tap value the search starts from |
| done | output | 1 | Search finished; result is on the taps |
| tap0 | output | 6 | Delay tap, lane 0 |
| tap1 | output | 6 | Delay tap, lane 1 |
| chkReq | output | 1 | One-cycle request for one pattern test |
| chkDone | input | 1 | Tester answer strobe |
| chkPass | input | 1 | Test result, valid with chkDone |
| patAddr | input | 10 | Pattern word address from the tester |
| patWord | output | 32 | Pattern word for that address |

## Verification
The bench targets the edges of the search. The first is a window that reaches the 32 ceiling, where a design that compares with the wrong bound either overshoots or stops early. The second is a window that starts at zero, where a wrong check would underflow the tap or set the lower edge to one. A one-tap window checks the minus-one and plus-one edge recording. A start tap outside the window and a start tap above the ceiling drive both turn-around paths on the very first test. A window ending at 63 has an edge sum that needs seven bits, and a design with a six-bit adder would return a tap near 24 instead of 56. The number of tester requests in each run shows whether two passes are needed per setting, and a `start` pulse in the middle of a search shows whether the engine restarts when it should not.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

  // Strobes from the control FSM to the tap datapath.
  typedef struct packed {
    logic load;     // take startTap as current and origin
    logic back;     // return current tap to origin
    logic inc;      // current tap + 1
    logic dec;      // current tap - 1
    logic upPass;   // upper edge = current tap
    logic upFail;   // upper edge = current tap - 1
    logic loPass;   // lower edge = current tap
    logic loFail;   // lower edge = current tap + 1
    logic commit;   // drive midpoint onto the lanes
  } tapCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FINAL = 2'd3
  } calState_t;

endpackage

// File: rtl/tapcal_pattern.sv
module tapcal_pattern #(
  parameter int GRP_W  = 8,
  parameter int DATA_W = 32,
  localparam int SEL_W  = $clog2(GRP_W / 2),
  localparam int ADDR_W = GRP_W + SEL_W,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [ADDR_W-1:0] wordAddr,
  output logic [DATA_W-1:0] wordData
);

  logic [GRP_W-1:0] grpIdx;
  logic [SEL_W-1:0] wordSel;
  logic             hiSet;
  logic             loSet;

  always_comb begin
    grpIdx   = wordAddr[ADDR_W-1:SEL_W];
    wordSel  = wordAddr[SEL_W-1:0];
    hiSet    = grpIdx[{wordSel, 1'b1}];
    loSet    = grpIdx[{wordSel, 1'b0}];
    wordData = {{HALF_W{hiSet}}, {HALF_W{loSet}}};
  end

endmodule

// File: rtl/tapcal_datapath.sv
module tapcal_datapath
  import tapcal_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_LIMIT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tapCmd_t          cmd,
  input  logic [TAP_W-1:0] startTap,
  output logic [TAP_W-1:0] tap0,
  output logic [TAP_W-1:0] tap1,
  output logic             atLimit,
  output logic             atZero
);

  localparam logic [TAP_W:0] LIMIT_X = (TAP_W + 1)'(TAP_LIMIT);

  logic [TAP_W-1:0] curTap, originTap, upperEdge, lowerEdge;
  logic [TAP_W-1:0] tap0Q, tap1Q, nextTap;
  logic [TAP_W:0]   edgeSum;
  logic [TAP_W-1:0] midTap;
  logic             moveTap;

  always_comb begin
    moveTap = cmd.load | cmd.back | cmd.inc | cmd.dec;
    if (cmd.load)      nextTap = startTap;
    else if (cmd.back) nextTap = originTap;
    else if (cmd.inc)  nextTap = curTap + 1'b1;
    else if (cmd.dec)  nextTap = curTap - 1'b1;
    else               nextTap = curTap;
    edgeSum = {1'b0, upperEdge} + {1'b0, lowerEdge};
    midTap  = edgeSum[TAP_W:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTap    <= '0;
      originTap <= '0;
      upperEdge <= '0;
      lowerEdge <= '0;
      tap0Q     <= '0;
      tap1Q     <= '0;
    end else begin
      curTap <= nextTap;
      if (cmd.load)   originTap <= startTap;
      if (cmd.upPass) upperEdge <= curTap;
      if (cmd.upFail) upperEdge <= curTap - 1'b1;
      if (cmd.loPass) lowerEdge <= curTap;
      if (cmd.loFail) lowerEdge <= curTap + 1'b1;
      if (cmd.commit) begin
        tap0Q <= midTap;
        tap1Q <= midTap + 1'b1;
      end else if (moveTap) begin
        tap0Q <= nextTap;
        tap1Q <= nextTap;
      end
    end
  end

  assign tap0    = tap0Q;
  assign tap1    = tap1Q;
  assign atLimit = {1'b0, curTap} >= LIMIT_X;
  assign atZero  = (curTap == '0);

endmodule

// File: rtl/tapcal_control.sv
module tapcal_control
  import tapcal_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    chkDone,
  input  logic    chkPass,
  input  logic    atLimit,
  input  logic    atZero,
  output tapCmd_t cmd,
  output logic    chkReq,
  output logic    busy,
  output logic    done
);

  calState_t state, stateNxt;
  logic goingUp, secondPass, doneQ;
  logic settle;   // current setting is decided this cycle

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    settle   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        cmd.load = 1'b1;
        stateNxt = ST_REQ;
      end
      ST_REQ: stateNxt = ST_WAIT;
      ST_WAIT: if (chkDone) begin
        if (!chkPass || secondPass) begin
          settle = 1'b1;
          if (goingUp) begin
            stateNxt = ST_REQ;
            if (!chkPass) begin
              cmd.upFail = 1'b1;
              cmd.back   = 1'b1;
            end else if (atLimit) begin
              cmd.upPass = 1'b1;
              cmd.back   = 1'b1;
            end else begin
              cmd.inc = 1'b1;
            end
          end else begin
            if (!chkPass) begin
              cmd.loFail = 1'b1;
              stateNxt   = ST_FINAL;
            end else if (atZero) begin
              cmd.loPass = 1'b1;
              stateNxt   = ST_FINAL;
            end else begin
              cmd.dec  = 1'b1;
              stateNxt = ST_REQ;
            end
          end
        end else begin
          stateNxt = ST_REQ;
        end
      end
      ST_FINAL: begin
        cmd.commit = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      goingUp    <= 1'b1;
      secondPass <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      state <= stateNxt;
      if (cmd.load) begin
        goingUp    <= 1'b1;
        secondPass <= 1'b0;
        doneQ      <= 1'b0;
      end
      if (state == ST_WAIT && chkDone) begin
        secondPass <= !settle;
        if (cmd.back) goingUp <= 1'b0;
      end
      if (cmd.commit) doneQ <= 1'b1;
    end
  end

  assign chkReq = (state == ST_REQ);
  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;

endmodule

// File: rtl/tapcal_top.sv
module tapcal_top
  import tapcal_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_LIMIT = 32,
  parameter int GRP_W     = 8,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = GRP_W + $clog2(GRP_W / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TAP_W-1:0]  startTap,
  output logic              done,
  output logic [TAP_W-1:0]  tap0,
  output logic [TAP_W-1:0]  tap1,
  output logic              chkReq,
  input  logic              chkDone,
  input  logic              chkPass,
  input  logic [ADDR_W-1:0] patAddr,
  output logic [DATA_W-1:0] patWord
);

  tapCmd_t tapCmd;
  logic    atLimit, atZero, busy;

  tapcal_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .chkDone (chkDone),
    .chkPass (chkPass),
    .atLimit (atLimit),
    .atZero  (atZero),
    .cmd     (tapCmd),
    .chkReq  (chkReq),
    .busy    (busy),
    .done    (done)
  );

  tapcal_datapath #(.TAP_W(TAP_W), .TAP_LIMIT(TAP_LIMIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (tapCmd),
    .startTap (startTap),
    .tap0     (tap0),
    .tap1     (tap1),
    .atLimit  (atLimit),
    .atZero   (atZero)
  );

  tapcal_pattern #(.GRP_W(GRP_W), .DATA_W(DATA_W)) u_pat (
    .wordAddr (patAddr),
    .wordData (patWord)
  );

endmodule

// File: rtl/tapcal_checker.sv
module tapcal_checker #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [TAP_W-1:0] startTap,
  input logic             chkReq,
  input logic             busy,
  input logic             done,
  input logic [TAP_W-1:0] tap0,
  input logic [TAP_W-1:0] tap1
);

  a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    chkReq |=> !chkReq);

  a_r3_lanes_match: assert property (@(posedge clk) disable iff (!rstN)
    chkReq |-> (tap0 == tap1));

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (tap0 == $past(startTap) && tap1 == $past(startTap) && !done));

  a_r7_result_lanes: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (tap1 == TAP_W'(tap0 + 1'b1)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(tap0) && $stable(tap1)));

  a_r8_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    chkReq |-> (busy && !done));

endmodule

bind tapcal_top tapcal_checker #(.TAP_W(TAP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .startTap (startTap),
  .chkReq   (chkReq),
  .busy     (busy),
  .done     (done),
  .tap0     (tap0),
  .tap1     (tap1)
);

// File: tb/tapcal_top_test.sv
module tapcal_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  startTap = '0;
  logic        done, chkReq;
  logic [5:0]  tap0, tap1;
  logic        chkDone = 1'b0;
  logic        chkPass = 1'b0;
  logic [9:0]  patAddr = '0;
  logic [31:0] patWord;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  // tester model state
  int winLo = 0, winHi = 0, lat = 1;
  int reqSeen = 0, laneMismatch = 0, cnt = 0;
  bit passNow = 0;

  // columns: window low, window high, start tap, tester latency, expected tap0
  localparam int NV = 9;
  localparam int VEC [0:NV-1][0:4] = '{
    '{ 5, 20, 12, 1, 12},
    '{ 0,  9,  3, 2,  4},
    '{20, 63, 25, 1, 26},
    '{ 0, 63,  0, 3, 16},
    '{ 7,  7,  7, 1,  7},
    '{10, 33, 32, 2, 21},
    '{20, 30, 10, 1, 10},
    '{ 3, 40, 40, 2, 21},
    '{50, 63, 63, 1, 56}
  };

  tapcal_top uut (
    .clk(clk), .rstN(rstN), .start(start), .startTap(startTap), .done(done),
    .tap0(tap0), .tap1(tap1), .chkReq(chkReq), .chkDone(chkDone),
    .chkPass(chkPass), .patAddr(patAddr), .patWord(patWord)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inWin(input int t);
    return (t >= winLo) && (t <= winHi);
  endfunction

  // Requests a correct search issues: two per passing setting, one per failing.
  function automatic int expReqs(input int lo, input int hi, input int s);
    int n = 0;
    int t = s;
    forever begin
      if (t < lo || t > hi) begin n += 1; break; end
      n += 2;
      if (t >= 32) break;
      t++;
    end
    t = s;
    forever begin
      if (t < lo || t > hi) begin n += 1; break; end
      n += 2;
      if (t == 0) break;
      t--;
    end
    return n;
  endfunction

  // Memory tester model: answers each request after lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      chkDone = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          chkDone = 1'b1;
          chkPass = passNow;
        end
      end
      if (chkReq) begin
        reqSeen++;
        if (tap0 != tap1) laneMismatch++;
        passNow = inWin(int'(tap0));
        cnt = lat;
      end
    end
  end

  task automatic runSearch(input int lo, input int hi, input int s, input int l,
                           input int expTap, input bit poke);
    int cyc = 0;
    winLo = lo; winHi = hi; lat = l;
    reqSeen = 0; laneMismatch = 0;
    @(negedge clk);
    startTap = 6'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tap0 == 6'(s) && tap1 == 6'(s) && !done, "R2 start load", tap0, s);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 6) begin
        startTap = 6'd40;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(done == 1'b1, "R7 done within bound", done, 1);
    check(tap0 == 6'(expTap), "R5 R6 R7 tap0 midpoint", tap0, expTap);
    check(tap1 == 6'(expTap + 1), "R7 tap1 midpoint+1", tap1, 6'(expTap + 1));
    check(reqSeen == expReqs(lo, hi, s), "R4 request count", reqSeen, expReqs(lo, hi, s));
    check(laneMismatch == 0, "R3 lanes equal at request", laneMismatch, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(tap0 == 0 && tap1 == 0, "R9 reset taps", {tap0, tap1}, 0);
    check(!done && !chkReq, "R9 reset done/req", {done, chkReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!chkReq && !done, "R9 idle after reset", {done, chkReq}, 0);

    // R1: pattern words
    for (int i = 0; i < 40; i++) begin
      int a = (i * 67 + 3) % 1024;
      int g = a >> 2;
      int k = a & 3;
      logic [31:0] e;
      e = {{16{g[2*k+1]}}, {16{g[2*k]}}};
      patAddr = 10'(a);
      #1;
      check(patWord == e, "R1 pattern word", patWord, e);
    end

    // Table-driven windows (R4 R5 R6 R7)
    for (int v = 0; v < NV; v++)
      runSearch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 1'b0);

    // R7: result holds while idle
    repeat (5) @(negedge clk);
    check(tap0 == 6'd56 && tap1 == 6'd57 && done && !chkReq, "R7 hold after done",
          {tap0, tap1}, {6'd56, 6'd57});

    // R8: start pulse mid-search is ignored
    runSearch(5, 20, 12, 2, 12, 1'b1);

    // R3: slow tester, engine waits
    runSearch(0, 4, 2, 7, 2, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule